// File: doc/BRIEF.md
# I2C Serial EEPROM Target

This block is an I2C target that acts as a small byte-addressed serial EEPROM. It oversamples the open-drain SCL and SDA lines with the system clock and detects start, repeated start and stop conditions. It decodes a control byte that carries a 7-bit device address and a read/write flag. It serves single-byte writes and three kinds of read: current-address, random and sequential. Storage is an internal register array. SDA is only ever pulled low.

Programming happens at the stop that closes a write transfer. A parameterized counter then models the self-timed programming cycle. While that counter runs, the block does not acknowledge any control byte, so a host can poll with a bare control byte until it gets an ACK. An address pointer survives between transfers. It always holds the address after the last byte accessed, which is what current-address and sequential reads use. When the write-protect input is high at the stop, the array behaves as read-only.

Top module: `i2c_eeprom_tgt`

## Requirements
- R1: After reset, sda_drive_o is 0, the address pointer is 0, and every array byte reads as 0xFF.
- R2: A control byte is sent MSB first: the device address is in bits 7:1 and the read/write flag in bit 0 (1 = read). When the address equals DEV_ADDR and no write cycle runs, the block pulls SDA low during the ninth clock. Any other address gets no ACK, and the block stays silent until the next start.
- R3: A byte write is a control byte with bit 0 = 0, then a word-address byte and then one data byte. The block ACKs both bytes after the control byte. Only the low log2(DEPTH) bits of the word address are used, and the data byte is programmed at the following stop.
- R4: After a stop that programs a byte, control bytes with either read/write value get no ACK for WR_CYCLES clock cycles. After that they are ACKed again.
- R5: After it ACKs a control byte with bit 0 = 1, the block shifts out the byte at the pointer, MSB first. It changes its SDA drive only while SCL is low.
- R6: The pointer holds the last accessed address plus one. After a write to n or a read of n, a current-address read returns the byte at n+1.
- R7: Random read: a write transfer loads the word address, then a repeated start and a control byte with bit 0 = 1 read from that address. A repeated start that cuts off a write transfer programs nothing and starts no write cycle.
- R8: When the host ACKs a read byte, the next sequential byte follows, and the pointer wraps from DEPTH-1 to 0. A host NACK ends the transmission, and the block releases SDA.
- R9: When wp_i is high at the stop, nothing is programmed and no write cycle starts, so the next control byte is ACKed at once. The data byte itself is still ACKed.
- R10: A second data byte in the same write transfer gets no ACK and is not stored. Only the first data byte is programmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, oversamples the bus |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| wp_i | input | 1 | Write protect, high blocks programming |
| sda_drive_o | output | 1 | 1 pulls SDA low (open drain) |

## Verification
The bench programs every address with an arithmetic pattern. It sets the upper word-address bits on odd addresses, which separates correct address truncation from aliasing. Every address is then read back randomly, and each random read is followed by a current-address read, which tells a correct pointer update apart from a stale or double-stepped one. A sequential read longer than the array shows the wrap and the handling of the final NACK. Ack polling right after each stop, with both read/write values, confirms that the busy window exists and that it ends. Write-protect, a second data byte and a repeated start after a data byte each change only the programming decision, so the bench reads the affected addresses back to tell them apart.

// File: rtl/i2c_ee_pkg.sv
`timescale 1ns/1ps
package i2c_ee_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_CTRL, ST_ADDR, ST_DATA, ST_ACK, ST_RD, ST_MACK, ST_SKIP
  } ee_state_e;
endpackage

// File: rtl/i2c_ee_sync.sv
`timescale 1ns/1ps
module i2c_ee_sync #(
  parameter int STAGES = 2,
  parameter int W      = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg <= '1;  // idle bus is high
    else         stg <= {stg[STAGES-2:0], d_i};
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/i2c_ee_bus_cond.sv
`timescale 1ns/1ps
module i2c_ee_bus_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_s_i,
  input  logic sda_s_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s_i;
      sda_q <= sda_s_i;
    end
  end

  assign scl_rise_o = scl_s_i & ~scl_q;
  assign scl_fall_o = ~scl_s_i & scl_q;
  // SDA edges count as conditions only with SCL high on both samples
  assign start_o = scl_s_i & scl_q & sda_q & ~sda_s_i;
  assign stop_o  = scl_s_i & scl_q & ~sda_q & sda_s_i;
endmodule

// File: rtl/i2c_ee_wcycle.sv
`timescale 1ns/1ps
module i2c_ee_wcycle #(
  parameter int CYC = 500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int CW = $clog2(CYC + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt <= '0;
    else if (start_i)     cnt <= CW'(CYC);
    else if (cnt != '0)   cnt <= cnt - CW'(1);
  end

  assign busy_o = (cnt != '0);

  assert_no_restart_busy_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_o);
endmodule

// File: rtl/i2c_ee_mem.sv
`timescale 1ns/1ps
module i2c_ee_mem #(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);
  logic [7:0] arr [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) arr[i] <= 8'hFF;
    end else if (we_i) begin
      arr[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = arr[raddr_i];
endmodule

// File: rtl/i2c_eeprom_tgt.sv
`timescale 1ns/1ps
module i2c_eeprom_tgt
  import i2c_ee_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h50,
  parameter int         DEPTH       = 16,
  parameter int         WR_CYCLES   = 500,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  input  logic wp_i,
  output logic sda_drive_o
);
  localparam int AW = $clog2(DEPTH);

  logic [1:0] line_s;
  logic scl_rise, scl_fall, start_det, stop_det;
  logic busy, mem_we;
  logic [7:0] mem_rdata;

  ee_state_e state, after_ack;
  logic [2:0]    bit_cnt;
  logic          byte_done, mack, drive, wr_pend;
  logic [7:0]    shreg, txreg, wr_data;
  logic [AW-1:0] ptr, wr_addr;

  i2c_ee_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
    .clk_i, .rst_ni, .d_i({scl_i, sda_i}), .q_o(line_s)
  );

  i2c_ee_bus_cond u_cond (
    .clk_i, .rst_ni,
    .scl_s_i(line_s[1]), .sda_s_i(line_s[0]),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  i2c_ee_wcycle #(.CYC(WR_CYCLES)) u_wcyc (
    .clk_i, .rst_ni, .start_i(mem_we), .busy_o(busy)
  );

  i2c_ee_mem #(.DEPTH(DEPTH), .AW(AW)) u_mem (
    .clk_i, .rst_ni, .we_i(mem_we), .waddr_i(wr_addr), .wdata_i(wr_data),
    .raddr_i(ptr), .rdata_o(mem_rdata)
  );

  // programming happens only at a stop that closes a write with a data byte
  assign mem_we = stop_det & wr_pend & ~wp_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state     <= ST_IDLE;
      after_ack <= ST_IDLE;
      bit_cnt   <= '0;
      byte_done <= 1'b0;
      mack      <= 1'b0;
      drive     <= 1'b0;
      wr_pend   <= 1'b0;
      shreg     <= '0;
      txreg     <= '0;
      wr_data   <= '0;
      wr_addr   <= '0;
      ptr       <= '0;
    end else if (start_det) begin
      state     <= ST_CTRL;
      bit_cnt   <= '0;
      byte_done <= 1'b0;
      drive     <= 1'b0;
      wr_pend   <= 1'b0;
    end else if (stop_det) begin
      state     <= ST_IDLE;
      byte_done <= 1'b0;
      drive     <= 1'b0;
      wr_pend   <= 1'b0;
    end else begin
      case (state)
        ST_CTRL, ST_ADDR, ST_DATA: begin
          if (scl_rise) begin
            shreg   <= {shreg[6:0], line_s[0]};
            bit_cnt <= bit_cnt + 3'd1;
            if (bit_cnt == 3'd7) byte_done <= 1'b1;
          end else if (scl_fall && byte_done) begin
            byte_done <= 1'b0;
            bit_cnt   <= '0;
            case (state)
              ST_CTRL: begin
                if (shreg[7:1] == DEV_ADDR && !busy) begin
                  drive     <= 1'b1;
                  state     <= ST_ACK;
                  after_ack <= shreg[0] ? ST_RD : ST_ADDR;
                end else begin
                  state <= ST_SKIP;
                end
              end
              ST_ADDR: begin
                ptr       <= shreg[AW-1:0];
                drive     <= 1'b1;
                state     <= ST_ACK;
                after_ack <= ST_DATA;
              end
              default: begin
                if (!wr_pend) begin
                  wr_pend   <= 1'b1;
                  wr_addr   <= ptr;
                  wr_data   <= shreg;
                  ptr       <= ptr + AW'(1);
                  drive     <= 1'b1;
                  state     <= ST_ACK;
                  after_ack <= ST_DATA;
                end else begin
                  state <= ST_SKIP;
                end
              end
            endcase
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            state <= after_ack;
            if (after_ack == ST_RD) begin
              txreg   <= mem_rdata;
              drive   <= ~mem_rdata[7];
              bit_cnt <= '0;
            end else begin
              drive <= 1'b0;
            end
          end
        end
        ST_RD: begin
          if (scl_rise) begin
            bit_cnt <= bit_cnt + 3'd1;
            if (bit_cnt == 3'd7) byte_done <= 1'b1;
          end else if (scl_fall) begin
            if (byte_done) begin
              byte_done <= 1'b0;
              drive     <= 1'b0;
              state     <= ST_MACK;
            end else begin
              txreg <= {txreg[6:0], 1'b0};
              drive <= ~txreg[6];
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) begin
            ptr  <= ptr + AW'(1);
            mack <= ~line_s[0];
          end else if (scl_fall) begin
            if (mack) begin
              txreg   <= mem_rdata;
              drive   <= ~mem_rdata[7];
              bit_cnt <= '0;
              state   <= ST_RD;
            end else begin
              state <= ST_SKIP;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_drive_o = drive;

  assert_busy_nack_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_CTRL && scl_fall && byte_done && busy && !start_det && !stop_det)
      |=> !sda_drive_o);

  assert_wp_no_cycle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_det && wp_i) |=> !$rose(busy));

  assert_first_bit_msb_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_ACK && scl_fall && after_ack == ST_RD && !start_det && !stop_det)
      |=> (sda_drive_o == !$past(mem_rdata[7])));

  assert_skip_silent_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_SKIP) |-> !sda_drive_o);
endmodule

// File: tb/tb_i2c_eeprom_tgt.sv
`timescale 1ns/1ps
module tb_i2c_eeprom_tgt;
  localparam int DEPTH = 16;
  localparam int WRC   = 500;
  localparam int Q     = 10;
  localparam logic [6:0] DEV = 7'h50;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, wp = 1'b0;
  logic drv;
  logic sda_bus;
  assign sda_bus = sda_m & ~drv;

  always #2.5 clk = ~clk;

  i2c_eeprom_tgt #(.DEV_ADDR(DEV), .DEPTH(DEPTH), .WR_CYCLES(WRC)) dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .wp_i(wp), .sda_drive_o(drv)
  );

  int n_chk = 0, n_bad = 0, viol = 0, ep = 0;
  logic [7:0] em [DEPTH];
  logic prev_drv = 1'b0, prev_scl = 1'b1;

  // R5 monitor: drive may only change while SCL is low
  always @(negedge clk) begin
    if (rst_n && scl_m && prev_scl && drv !== prev_drv) viol++;
    prev_drv = drv;
    prev_scl = scl_m;
  end

  function automatic logic [7:0] pat(int a);
    return 8'((a * 37 + 5) & 255);
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wt();
    repeat (Q) @(negedge clk);
  endtask

  task automatic i_start();
    sda_m = 1'b1; wt(); scl_m = 1'b1; wt(); sda_m = 1'b0; wt(); scl_m = 1'b0; wt();
  endtask

  task automatic i_stop();
    sda_m = 1'b0; wt(); scl_m = 1'b1; wt(); sda_m = 1'b1; wt();
  endtask

  task automatic send(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wt(); scl_m = 1'b1; wt(); scl_m = 1'b0;
    end
    sda_m = 1'b1; wt(); scl_m = 1'b1; wt();
    ack = ~sda_bus;
    scl_m = 1'b0; wt();
  endtask

  task automatic recv(input logic mk, output logic [7:0] b);
    b = '0;
    for (int i = 0; i < 8; i++) begin
      wt(); scl_m = 1'b1; wt(); b = {b[6:0], sda_bus}; scl_m = 1'b0;
    end
    sda_m = ~mk; wt(); scl_m = 1'b1; wt(); scl_m = 1'b0; wt(); sda_m = 1'b1;
  endtask

  task automatic do_cur(string tag);
    logic a; logic [7:0] b;
    i_start(); send({DEV, 1'b1}, a); recv(1'b0, b); i_stop();
    chk({tag, " ctrl ack"}, a, 1);
    chk(tag, b, em[ep]);
    ep = (ep + 1) % DEPTH;
  endtask

  task automatic do_rand(int ad, string tag);
    logic a0, a1, a2; logic [7:0] b;
    i_start(); send({DEV, 1'b0}, a0); send(8'(ad), a1);
    i_start(); send({DEV, 1'b1}, a2); recv(1'b0, b); i_stop();
    chk({tag, " acks"}, {a0, a1, a2}, 3'b111);
    chk(tag, b, em[ad]);
    ep = (ad + 1) % DEPTH;
  endtask

  task automatic poll(input logic rw, output logic a);
    i_start(); send({DEV, rw}, a); i_stop();
  endtask

  task automatic wait_ready(string tag);
    logic a; int n;
    n = 0; a = 1'b0;
    while (!a && n < 10) begin poll(1'b0, a); if (!a) n++; end
    chk(tag, (a && n >= 1 && n <= 3) ? 1 : 0, 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic a0, a1, a2, a3; logic [7:0] b;
    for (int i = 0; i < DEPTH; i++) em[i] = 8'hFF;
    repeat (5) @(negedge clk);
    rst_n = 1'b1; wt();
    chk("R1 drive idle after reset", drv, 0);
    do_cur("R1 erased byte at pointer 0");

    // R2 foreign address
    i_start(); send({7'h51, 1'b0}, a0); send(8'h00, a1); i_stop();
    chk("R2 foreign ctrl nack", a0, 0);
    chk("R2 silent until start", a1, 0);

    // R3/R4 fill sweep
    for (int a = 0; a < DEPTH; a++) begin
      i_start(); send({DEV, 1'b0}, a0);
      send((a % 2 == 1) ? 8'(a) | 8'hF0 : 8'(a), a1);
      send(pat(a), a2); i_stop();
      chk("R3 write acks", {a0, a1, a2}, 3'b111);
      em[a] = pat(a); ep = (a + 1) % DEPTH;
      poll(a[0], a3);
      chk("R4 ctrl nack while busy", a3, 0);
      wait_ready("R4 ack after write cycle");
    end
    do_cur("R6 R8 pointer wrap after last write");

    for (int a = 0; a < DEPTH; a++) begin
      do_rand(a, "R7 random read");
      do_cur("R6 current read follows access");
    end

    // R8 sequential with wrap
    i_start(); send({DEV, 1'b0}, a0); send(8'd5, a1);
    i_start(); send({DEV, 1'b1}, a2);
    for (int i = 0; i < DEPTH + 3; i++) begin
      recv(i < DEPTH + 2, b);
      chk("R8 sequential byte", b, em[(5 + i) % DEPTH]);
    end
    i_stop();
    chk("R8 released after nack", drv, 0);
    ep = (5 + DEPTH + 3) % DEPTH;
    do_cur("R6 after sequential read");

    // R9 write protect
    wp = 1'b1;
    i_start(); send({DEV, 1'b0}, a0); send(8'd2, a1); send(8'h5A, a2); i_stop();
    chk("R9 data still acked", a2, 1);
    poll(1'b0, a3);
    chk("R9 no write cycle", a3, 1);
    wp = 1'b0;
    do_rand(2, "R9 byte unchanged");

    // R10 second data byte
    i_start(); send({DEV, 1'b0}, a0); send(8'd7, a1); send(8'h11, a2); send(8'h22, a3); i_stop();
    chk("R10 first data ack", a2, 1);
    chk("R10 second data nack", a3, 0);
    em[7] = 8'h11; ep = 8;
    poll(1'b1, a3);
    chk("R4 read ctrl nack while busy", a3, 0);
    wait_ready("R4 ack after write cycle");
    do_cur("R10 next byte untouched");
    do_rand(7, "R10 first byte stored");

    // R7 repeated start after data byte
    i_start(); send({DEV, 1'b0}, a0); send(8'd9, a1); send(8'h33, a2);
    i_start(); send({DEV, 1'b1}, a3); recv(1'b0, b); i_stop();
    chk("R7 read after cut write", b, em[10]);
    poll(1'b0, a3);
    chk("R7 no write cycle after cut", a3, 1);
    do_rand(9, "R7 cut write not stored");

    chk("R5 drive changes only with SCL low", viol, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule